// File: doc/BRIEF.md
# Infrared Run-Length Sampler

The block watches a demodulated infrared receive line and turns it into a stream of run-length symbols. The line is sampled once every 64 or 128 clock cycles. After an optional polarity inversion, a two-stage synchronizer and a glitch filter, the cleaned level is measured in sample periods. Each time the level changes, the run that just ended leaves the block as one byte. The top bit of the byte is the level and the low seven bits are the duration minus one. A run longer than 128 samples is cut into several bytes of the same level.

A packet opens only after a pulse has lasted a programmable number of samples. Pulses that are too short to open a packet leave no trace. A packet closes after a long enough stretch of space. When it closes, the pending space run goes out as the last byte and a one-cycle packet-end strobe is raised. A downstream decoder collects the bytes into a buffer and decodes them on the strobe.

Symbols leave through a valid/ready port backed by one register. A symbol is held stable until it is accepted. The consumer must take each symbol within one sample period, which is at least 64 cycles. A symbol produced while the previous one is still waiting is discarded. The packet-end strobe does not wait for sym_ready.

Top module: `ir_runlen_sampler`

## Requirements
- R1: A sample is taken every 64 clock cycles when cfg_div128 is 0, and every 128 cycles when it is 1. Every duration is counted in these sample periods.
- R2: Symbol encoding: bit 7 is the level, where 1 means pulse (light present after inversion) and 0 means space. Bits 6:0 hold the run length minus one.
- R3: A run of more than 128 samples is emitted as one 128-sample symbol (0xFF for pulse, 0x7F for space) each time 128 samples have been counted, and the remainder follows as a normal symbol.
- R4: The cleaned level changes only after the synchronized input has differed from it for F consecutive samples. F is cfg_filter, with 0 treated as 1. Shorter pulses are ignored, and accepted runs keep their length.
- R5: Outside a packet, a packet opens when a pulse reaches T consecutive samples. T = cfg_active+1, multiplied by 128 when cfg_active_x128 is 1. The first pulse symbol counts from the T-th sample onward, so a P-sample pulse gives 0x80 | (P-T). Shorter pulses produce nothing.
- R6: Inside a packet, on the ((cfg_idle+1)*128)-th consecutive space sample the pending space run, excluding that sample, is emitted as the last symbol. In the same cycle pkt_end pulses for exactly one clock, and the block returns to waiting for activity.
- R7: When cfg_invert is 1 the input is inverted before synchronization, so a low ir_in is a pulse.
- R8: A valid symbol and its data hold until sym_ready is high. A symbol produced while an unaccepted one waits is discarded, and the waiting one is kept.
- R9: While reset is asserted and just after it is released, sym_valid and pkt_end are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated infrared line |
| cfg_invert | input | 1 | Invert the line before sampling |
| cfg_div128 | input | 1 | Sample divider select: 0 = /64, 1 = /128 |
| cfg_filter | input | FILT_W (6) | Glitch filter length in samples |
| cfg_idle | input | IDLE_W (8) | Idle limit, in units of 128 samples, minus one |
| cfg_active | input | ACT_W (8) | Activation length minus one |
| cfg_active_x128 | input | 1 | Multiply the activation length by 128 |
| sym_ready | input | 1 | Consumer accepts the symbol |
| sym_valid | output | 1 | Symbol present |
| sym_data | output | 8 | Level bit and duration minus one |
| pkt_end | output | 1 | One-cycle packet-end strobe |

## Verification
A level sampled on a divider tick passes through the filter register and reaches the run builder on a later tick. Two clocks after the tick that closes a run, the byte is on sym_data with sym_valid high. pkt_end rises in the same cycle as the closing space byte.

Because of that pipeline, the bench does not check absolute cycles. It holds each input level for an exact multiple of the sample period, starting at a fixed phase, so every run is sampled a known number of times. A monitor records each accepted byte and each pkt_end strobe at the falling edge, and the recorded stream is compared with the expected one. Each scenario waits the idle limit plus a few samples before comparing, which covers the pipeline latency.

// File: rtl/ir_rl_pkg.sv
`timescale 1ns/1ps
package ir_rl_pkg;
  localparam int SYM_W    = 8;
  localparam int DUR_W    = SYM_W - 1;
  localparam int RUN_MAX  = 1 << DUR_W;
  localparam int SCALE_SH = 7;
  localparam int DIV_FAST = 64;
  localparam int DIV_SLOW = 128;
  localparam int DIV_W    = $clog2(DIV_SLOW);

  typedef enum logic {ST_WAIT, ST_PKT} rl_state_t;
endpackage

// File: rtl/ir_rl_tick.sv
`timescale 1ns/1ps
module ir_rl_tick
  import ir_rl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic div_slow,
  output logic tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim = div_slow ? DIV_W'(DIV_SLOW - 1) : DIV_W'(DIV_FAST - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= lim) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + DIV_W'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_rl_front.sv
`timescale 1ns/1ps
module ir_rl_front #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              ir_raw,
  input  logic              invert,
  input  logic [FILT_W-1:0] filt_len,
  output logic              level
);
  localparam int RW = FILT_W + 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   synced;
  logic [FILT_W-1:0]      need;
  logic [FILT_W-1:0]      diff_cnt;
  logic [RW-1:0]          diff_nx;

  // inversion sits ahead of the synchronizer so both move together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_raw ^ invert};
  end

  assign synced  = sync_q[SYNC_STAGES-1];
  assign need    = (filt_len == '0) ? FILT_W'(1) : filt_len;
  assign diff_nx = RW'(diff_cnt) + RW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level    <= 1'b0;
      diff_cnt <= '0;
    end else if (tick) begin
      if (synced != level) begin
        if (diff_nx >= RW'(need)) begin
          level    <= synced;
          diff_cnt <= '0;
        end else begin
          diff_cnt <= diff_nx[FILT_W-1:0];
        end
      end else begin
        diff_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/ir_rl_runlen.sv
`timescale 1ns/1ps
module ir_rl_runlen
  import ir_rl_pkg::*;
#(
  parameter int IDLE_W = 8,
  parameter int ACT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             level,
  input  logic [IDLE_W-1:0] idle_units,
  input  logic [ACT_W-1:0] act_len,
  input  logic             act_x128,
  output logic             emit_v,
  output logic [SYM_W-1:0] emit_d,
  output logic             end_v
);
  localparam int CW = ((ACT_W > IDLE_W) ? ACT_W : IDLE_W) + 1 + SCALE_SH;
  localparam int RCW = DUR_W + 1;

  rl_state_t        state;
  logic [CW-1:0]    act_lim, idle_lim, act_cnt, sp_cnt, act_nx, sp_nx;
  logic [RCW-1:0]   run_cnt, run_m1;
  logic             run_lvl;

  always_comb begin
    act_lim = CW'(act_len) + CW'(1);
    if (act_x128) act_lim = act_lim << SCALE_SH;
    idle_lim = (CW'(idle_units) + CW'(1)) << SCALE_SH;
    act_nx   = act_cnt + CW'(1);
    sp_nx    = sp_cnt + CW'(1);
    run_m1   = run_cnt - RCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_WAIT;
      act_cnt <= '0;
      sp_cnt  <= '0;
      run_cnt <= RCW'(1);
      run_lvl <= 1'b0;
      emit_v  <= 1'b0;
      emit_d  <= '0;
      end_v   <= 1'b0;
    end else begin
      emit_v <= 1'b0;
      end_v  <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_WAIT: begin
            if (level) begin
              if (act_nx >= act_lim) begin
                state   <= ST_PKT;
                run_lvl <= 1'b1;
                run_cnt <= RCW'(1);
                sp_cnt  <= '0;
                act_cnt <= '0;
              end else begin
                act_cnt <= act_nx;
              end
            end else begin
              act_cnt <= '0;
            end
          end
          ST_PKT: begin
            sp_cnt <= level ? '0 : sp_nx;
            if (!level && sp_nx >= idle_lim) begin
              emit_v  <= 1'b1;
              emit_d  <= {run_lvl, run_m1[DUR_W-1:0]};
              end_v   <= 1'b1;
              state   <= ST_WAIT;
              act_cnt <= '0;
              sp_cnt  <= '0;
            end else if (level == run_lvl) begin
              if (run_cnt == RCW'(RUN_MAX)) begin
                emit_v  <= 1'b1;
                emit_d  <= {run_lvl, {DUR_W{1'b1}}};
                run_cnt <= RCW'(1);
              end else begin
                run_cnt <= run_cnt + RCW'(1);
              end
            end else begin
              emit_v  <= 1'b1;
              emit_d  <= {run_lvl, run_m1[DUR_W-1:0]};
              run_lvl <= level;
              run_cnt <= RCW'(1);
            end
          end
          default: state <= ST_WAIT;
        endcase
      end
    end
  end
endmodule

// File: rtl/ir_runlen_sampler.sv
`timescale 1ns/1ps
module ir_runlen_sampler
  import ir_rl_pkg::*;
#(
  parameter int FILT_W      = 6,
  parameter int IDLE_W      = 8,
  parameter int ACT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              cfg_invert,
  input  logic              cfg_div128,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic [IDLE_W-1:0] cfg_idle,
  input  logic [ACT_W-1:0]  cfg_active,
  input  logic              cfg_active_x128,
  input  logic              sym_ready,
  output logic              sym_valid,
  output logic [SYM_W-1:0]  sym_data,
  output logic              pkt_end
);
  logic             tick;
  logic             level;
  logic             emit_v;
  logic [SYM_W-1:0] emit_d;
  logic             end_v;

  ir_rl_tick u_tick (
    .clk(clk), .rst_n(rst_n), .div_slow(cfg_div128), .tick(tick)
  );

  ir_rl_front #(.SYNC_STAGES(SYNC_STAGES), .FILT_W(FILT_W)) u_front (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ir_raw(ir_in),
    .invert(cfg_invert), .filt_len(cfg_filter), .level(level)
  );

  ir_rl_runlen #(.IDLE_W(IDLE_W), .ACT_W(ACT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .tick(tick), .level(level),
    .idle_units(cfg_idle), .act_len(cfg_active), .act_x128(cfg_active_x128),
    .emit_v(emit_v), .emit_d(emit_d), .end_v(end_v)
  );

  // single output slot: a new symbol while the slot is stuck is dropped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_valid <= 1'b0;
      sym_data  <= '0;
      pkt_end   <= 1'b0;
    end else begin
      pkt_end <= end_v;
      if (emit_v && (!sym_valid || sym_ready)) begin
        sym_valid <= 1'b1;
        sym_data  <= emit_d;
      end else if (sym_valid && sym_ready) begin
        sym_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ir_rl_checker.sv
`timescale 1ns/1ps
module ir_rl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sym_valid,
  input logic       sym_ready,
  input logic [7:0] sym_data,
  input logic       pkt_end,
  input logic       emit_v
);
  logic [7:0] gap;
  logic       seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (emit_v) begin
      gap  <= '0;
      seen <= 1'b1;
    end else if (gap != 8'hFF) begin
      gap <= gap + 8'd1;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid && !sym_ready |=> sym_valid && $stable(sym_data)); // R8
  AST_END_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |=> !pkt_end); // R6
  AST_END_WITH_SYMBOL: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end |-> sym_valid); // R6
  AST_SAMPLE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    emit_v && seen |-> gap >= 8'd63); // R1
endmodule

bind ir_runlen_sampler ir_rl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
  .sym_data(sym_data), .pkt_end(pkt_end), .emit_v(emit_v)
);

// File: tb/tb_ir_runlen_sampler.sv
`timescale 1ns/1ps
module tb_ir_runlen_sampler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_in = 1'b0;
  logic       cfg_invert = 1'b0;
  logic       cfg_div128 = 1'b0;
  logic [5:0] cfg_filter = '0;
  logic [7:0] cfg_idle = '0;
  logic [7:0] cfg_active = '0;
  logic       cfg_active_x128 = 1'b0;
  logic       sym_ready = 1'b1;
  logic       sym_valid;
  logic [7:0] sym_data;
  logic       pkt_end;

  int checks = 0;
  int fails = 0;
  int per = 64;
  bit done = 0;
  int got[$];
  int exp_q[$];
  localparam int END_MARK = 256;

  always #2.5 clk = ~clk;

  ir_runlen_sampler dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .cfg_invert(cfg_invert),
    .cfg_div128(cfg_div128), .cfg_filter(cfg_filter), .cfg_idle(cfg_idle),
    .cfg_active(cfg_active), .cfg_active_x128(cfg_active_x128),
    .sym_ready(sym_ready), .sym_valid(sym_valid), .sym_data(sym_data),
    .pkt_end(pkt_end)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (sym_valid && sym_ready) got.push_back(int'(sym_data));
      if (pkt_end) got.push_back(END_MARK);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input bit lvl, input int samples);
    ir_in = lvl;
    repeat (samples * per) @(negedge clk);
  endtask

  task automatic start_case();
    got.delete();
    exp_q.delete();
  endtask

  task automatic check_stream(input string req);
    chk({req, " stream length"}, got.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      if (i < got.size()) chk(req, got[i], exp_q[i]);
    end
  endtask

  task automatic t_reset();
    chk("R9 sym_valid in reset", int'(sym_valid), 0);
    chk("R9 pkt_end in reset", int'(pkt_end), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 sym_valid after reset", int'(sym_valid), 0);
  endtask

  // R2 R5: basic packet, activation T=4
  task automatic t_basic();
    start_case();
    cfg_active = 8'd3;
    hold(1'b0, 3);
    hold(1'b1, 10);
    hold(1'b0, 5);
    hold(1'b1, 3);
    hold(1'b0, 132);
    exp_q = '{8'h86, 8'h04, 8'h82, 8'h7E, END_MARK};
    check_stream("R2/basic");
  endtask

  task automatic t_split();
    start_case();
    cfg_active = 8'd0;
    hold(1'b1, 300);
    hold(1'b0, 132);
    exp_q = '{8'hFF, 8'hFF, 8'hAB, 8'h7E, END_MARK};
    check_stream("R3 split");
  endtask

  task automatic t_glitch();
    start_case();
    cfg_filter = 6'd4;
    hold(1'b1, 3);
    hold(1'b0, 10);
    hold(1'b1, 6);
    hold(1'b0, 136);
    exp_q = '{8'h85, 8'h7E, END_MARK};
    check_stream("R4 filter");
    cfg_filter = 6'd0;
  endtask

  task automatic t_threshold();
    start_case();
    cfg_active = 8'd7;
    hold(1'b1, 5);
    hold(1'b0, 20);
    chk("R5 short pulse silent", got.size(), 0);
    hold(1'b1, 8);
    hold(1'b0, 132);
    exp_q = '{8'h80, 8'h7E, END_MARK};
    check_stream("R5 threshold");
    start_case();
    cfg_active = 8'd0;
    cfg_active_x128 = 1'b1;
    hold(1'b1, 130);
    hold(1'b0, 132);
    exp_q = '{8'h82, 8'h7E, END_MARK};
    check_stream("R5 scaled threshold");
    cfg_active_x128 = 1'b0;
  endtask

  task automatic t_invert();
    start_case();
    ir_in = 1'b1;
    cfg_invert = 1'b1;
    hold(1'b1, 4);
    hold(1'b0, 5);
    hold(1'b1, 132);
    exp_q = '{8'h84, 8'h7E, END_MARK};
    check_stream("R7 invert");
    ir_in = 1'b0;
    cfg_invert = 1'b0;
    repeat (4 * per) @(negedge clk);
  endtask

  task automatic t_div128();
    start_case();
    cfg_div128 = 1'b1;
    per = 128;
    hold(1'b0, 2);
    hold(1'b1, 4);
    hold(1'b0, 132);
    exp_q = '{8'h83, 8'h7E, END_MARK};
    check_stream("R1 divide by 128");
    cfg_div128 = 1'b0;
    per = 64;
    hold(1'b0, 2);
  endtask

  task automatic t_idle();
    start_case();
    cfg_idle = 8'd1;
    hold(1'b1, 2);
    hold(1'b0, 200);
    chk("R6 no early end", got.size(), 2);
    hold(1'b0, 60);
    exp_q = '{8'h81, 8'h7F, 8'h7E, END_MARK};
    check_stream("R6 idle limit");
    cfg_idle = 8'd0;
  endtask

  task automatic t_backpressure();
    start_case();
    sym_ready = 1'b0;
    hold(1'b1, 3);
    hold(1'b0, 132);
    chk("R8 held valid", int'(sym_valid), 1);
    chk("R8 held data", int'(sym_data), 8'h82);
    @(posedge clk);
    #1 sym_ready = 1'b1;
    repeat (3) @(negedge clk);
    exp_q = '{END_MARK, 8'h82};
    check_stream("R8 drop while busy");
    chk("R8 slot empty", int'(sym_valid), 0);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    t_reset();
    t_basic();
    t_split();
    t_glitch();
    t_threshold();
    t_invert();
    t_div128();
    t_idle();
    t_backpressure();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule